// File: doc/BRIEF.md
# Multiply-Accumulate Tap Engine

This block computes one filter tap per command. It fetches a signed 16-bit coefficient through a coefficient pointer that cycles around a ring held between a base and a limit address. It then fetches a signed 16-bit sample through a sample pointer that only ever moves forward. It multiplies the two words and adds the 32-bit product into a 32-bit accumulator. A filter pass begins with the clearing command and then issues the plain accumulate command once for each remaining tap. While the engine is idle it can also shift the accumulator right arithmetically.

The engine talks to memory through a single 16-bit read port. It raises a request with an address and holds both until memory answers with ready. Two sticky flags record signed accumulation overflow, one for the positive direction and one for the negative direction. Once either flag is set, it locks the other out.

The controller has four states: IDLE, COEF, SAMP and ACCUM. IDLE goes to COEF when a clearing or plain command is accepted. COEF goes to SAMP when the coefficient read completes. SAMP goes to ACCUM when the sample read completes. ACCUM always returns to IDLE after one cycle. The controller stays in COEF or SAMP while memory is not ready.

Top module: `mac_tap_engine`

## Requirements
- R1: After reset, acc_out is 0, ovf_pos and ovf_neg are 0, and busy, done and mem_req are 0.
- R2: An accepted cmd_start clears the accumulator. When the tap completes, acc_out equals coef*sample. Both words are signed two's complement and the product is 32 bits.
- R3: An accepted cmd_acc adds coef*sample to the existing accumulator without clearing it. The sum wraps modulo 2^32 and never saturates.
- R4: The coefficient is read at address coef_ptr. The pointer then becomes coef_ptr+2, unless that value is greater than the limit (unsigned compare), in which case it is reloaded with the base.
- R5: The sample is read at address samp_ptr, after the coefficient read. The pointer then becomes samp_ptr+2 and never wraps back to the base.
- R6: An accumulation that overflows in the positive direction (both addends non-negative, sum negative) sets ovf_pos. The flag stays set until it is cleared.
- R7: An accumulation that overflows in the negative direction (both addends negative, sum non-negative) sets ovf_neg. The flag stays set until it is cleared.
- R8: An accumulation does not change ovf_neg while ovf_pos is set, and does not change ovf_pos while ovf_neg is set. The two flags are therefore never set together.
- R9: In IDLE, with no tap command present, cmd_shift sets acc_out to acc_out arithmetically shifted right by shift_amt (0 to 31). The vacated bits are filled with the sign bit, and the new value appears the next cycle.
- R10: A flag_clr pulse clears both flags on the next edge. It takes priority over a flag being set in the same cycle.
- R11: A tap raises busy from the cycle after acceptance. done is a single-cycle pulse in the cycle after the accumulate. While mem_req is high and mem_ready is low, mem_req and mem_addr hold their values.
- R12: cmd_start, cmd_acc and cmd_shift arriving while busy is high have no effect on the accumulator or the pointers.
- R13: In IDLE with no command present, ld_ptrs loads the base, limit, coefficient pointer and sample pointer from the ld_* inputs. Command priority in IDLE is cmd_start, then cmd_acc, then cmd_shift, then ld_ptrs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Clear accumulator and run one tap |
| cmd_acc | input | 1 | Run one tap, accumulating |
| cmd_shift | input | 1 | Arithmetic right shift of the accumulator |
| shift_amt | input | 5 | Shift distance |
| flag_clr | input | 1 | Clear both overflow flags |
| ld_ptrs | input | 1 | Load pointer set |
| ld_base | input | 16 | Ring base address |
| ld_limit | input | 16 | Ring limit address |
| ld_coef | input | 16 | Initial coefficient pointer |
| ld_samp | input | 16 | Initial sample pointer |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read byte address |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Read data valid this cycle |
| busy | output | 1 | Tap in progress |
| done | output | 1 | Tap finished pulse |
| acc_out | output | 32 | Accumulator |
| ovf_pos | output | 1 | Positive overflow flag |
| ovf_neg | output | 1 | Negative overflow flag |
| coef_ptr | output | 16 | Current coefficient pointer |
| samp_ptr | output | 16 | Current sample pointer |

## Verification
On every cycle, the assertions check that the flags are mutually exclusive and sticky, that flag_clr wins, that the shift result is exact, that done lasts a single cycle, and that request and address stay stable while memory stalls. Other behaviours can only be shown by the bench's scenarios against its reference model, because they depend on memory contents and on the history of the pointers. These are the product values, the ring wrap of the coefficient pointer at the limit, the forward-only sample pointer, the wrapped sums after overflow, the lockout between the flags, and the fact that commands issued during a busy tap are ignored.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COEF  = 2'd1,
        ST_SAMP  = 2'd2,
        ST_ACCUM = 2'd3
    } tap_state_e;
endpackage

// File: rtl/mac_ptr_step.sv
module mac_ptr_step #(
    parameter int AW   = 16,
    parameter bit CIRC = 1'b1
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STEP = AW'(2);

    logic [AW-1:0] inc;
    assign inc = cur + STEP;

    generate
        if (CIRC) begin : g_ring
            // wrap back to the base once the advanced pointer passes the limit
            assign nxt = (inc > limit) ? base : inc;
        end else begin : g_lin
            logic unused_ring;
            assign unused_ring = ^{base, limit};
            assign nxt = inc;
        end
    endgenerate
endmodule

// File: rtl/mac_acc_add.sv
module mac_acc_add #(
    parameter int DW = 16
) (
    input  logic [2*DW-1:0] acc,
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    output logic [2*DW-1:0] sum,
    output logic            pos_ovf,
    output logic            neg_ovf
);
    localparam int RW = 2 * DW;

    logic signed [RW-1:0] prod;
    assign prod = $signed(op_a) * $signed(op_b);
    assign sum  = acc + prod;

    // overflow only when both addends share a sign that the sum lacks
    assign pos_ovf = ~acc[RW-1] & ~prod[RW-1] &  sum[RW-1];
    assign neg_ovf =  acc[RW-1] &  prod[RW-1] & ~sum[RW-1];
endmodule

// File: rtl/mac_tap_engine.sv
module mac_tap_engine
    import mac_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_start,
    input  logic                  cmd_acc,
    input  logic                  cmd_shift,
    input  logic [$clog2(2*DW)-1:0] shift_amt,
    input  logic                  flag_clr,
    input  logic                  ld_ptrs,
    input  logic [AW-1:0]         ld_base,
    input  logic [AW-1:0]         ld_limit,
    input  logic [AW-1:0]         ld_coef,
    input  logic [AW-1:0]         ld_samp,
    output logic                  mem_req,
    output logic [AW-1:0]         mem_addr,
    input  logic [DW-1:0]         mem_rdata,
    input  logic                  mem_ready,
    output logic                  busy,
    output logic                  done,
    output logic [2*DW-1:0]       acc_out,
    output logic                  ovf_pos,
    output logic                  ovf_neg,
    output logic [AW-1:0]         coef_ptr,
    output logic [AW-1:0]         samp_ptr
);
    localparam int RW = 2 * DW;

    tap_state_e state, state_nxt;

    logic [RW-1:0] acc_q;
    logic          ovf_p_q, ovf_n_q, done_q;
    logic [AW-1:0] base_q, limit_q, b_q, x_q;
    logic [DW-1:0] coef_q, samp_q;

    logic [AW-1:0] b_nxt, x_nxt;
    logic [RW-1:0] sum, shifted;
    logic          add_pos, add_neg;
    logic          go_start, go_acc, go_shift, go_load;

    mac_ptr_step #(.AW(AW), .CIRC(1'b1)) u_coef_step (
        .cur(b_q), .base(base_q), .limit(limit_q), .nxt(b_nxt)
    );

    mac_ptr_step #(.AW(AW), .CIRC(1'b0)) u_samp_step (
        .cur(x_q), .base(base_q), .limit(limit_q), .nxt(x_nxt)
    );

    mac_acc_add #(.DW(DW)) u_add (
        .acc(acc_q), .op_a(coef_q), .op_b(samp_q),
        .sum(sum), .pos_ovf(add_pos), .neg_ovf(add_neg)
    );

    assign shifted  = $signed(acc_q) >>> shift_amt;

    // IDLE command priority: start, acc, shift, pointer load
    assign go_start = cmd_start;
    assign go_acc   = cmd_acc & ~cmd_start;
    assign go_shift = cmd_shift & ~cmd_start & ~cmd_acc;
    assign go_load  = ld_ptrs & ~cmd_shift & ~cmd_start & ~cmd_acc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (go_start || go_acc) state_nxt = ST_COEF;
            ST_COEF:  if (mem_ready)          state_nxt = ST_SAMP;
            ST_SAMP:  if (mem_ready)          state_nxt = ST_ACCUM;
            ST_ACCUM:                         state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = b_q;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_COEF:  begin mem_req = 1'b1; mem_addr = b_q; end
            ST_SAMP:  begin mem_req = 1'b1; mem_addr = x_q; end
            ST_ACCUM: mem_addr = x_q;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            ovf_p_q <= 1'b0;
            ovf_n_q <= 1'b0;
            done_q  <= 1'b0;
            base_q  <= '0;
            limit_q <= '0;
            b_q     <= '0;
            x_q     <= '0;
            coef_q  <= '0;
            samp_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go_start) begin
                        acc_q <= '0;
                    end else if (go_shift) begin
                        acc_q <= shifted;
                    end else if (go_load) begin
                        base_q  <= ld_base;
                        limit_q <= ld_limit;
                        b_q     <= ld_coef;
                        x_q     <= ld_samp;
                    end
                end
                ST_COEF: if (mem_ready) begin
                    coef_q <= mem_rdata;
                    b_q    <= b_nxt;
                end
                ST_SAMP: if (mem_ready) begin
                    samp_q <= mem_rdata;
                    x_q    <= x_nxt;
                end
                ST_ACCUM: begin
                    acc_q  <= sum;
                    done_q <= 1'b1;
                    if (add_pos && !ovf_n_q) ovf_p_q <= 1'b1;
                    if (add_neg && !ovf_p_q) ovf_n_q <= 1'b1;
                end
            endcase
            if (flag_clr) begin
                ovf_p_q <= 1'b0;
                ovf_n_q <= 1'b0;
            end
        end
    end

    assign done     = done_q;
    assign acc_out  = acc_q;
    assign ovf_pos  = ovf_p_q;
    assign ovf_neg  = ovf_n_q;
    assign coef_ptr = b_q;
    assign samp_ptr = x_q;
endmodule

// File: rtl/mac_tap_checker.sv
module mac_tap_checker #(
    parameter int AW = 16,
    parameter int RW = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_start,
    input logic                    cmd_acc,
    input logic                    cmd_shift,
    input logic [$clog2(RW)-1:0]   shift_amt,
    input logic                    flag_clr,
    input logic                    busy,
    input logic                    done,
    input logic                    mem_req,
    input logic                    mem_ready,
    input logic [AW-1:0]           mem_addr,
    input logic [RW-1:0]           acc_out,
    input logic                    ovf_pos,
    input logic                    ovf_neg
);
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_pos && ovf_neg)); // R8

    AST_POS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pos && !flag_clr |=> ovf_pos); // R6

    AST_NEG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_neg && !flag_clr |=> ovf_neg); // R7

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !ovf_pos && !ovf_neg); // R10

    AST_SHIFT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_shift && !cmd_start && !cmd_acc
        |=> acc_out == RW'($signed($past(acc_out)) >>> $past(shift_amt))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R11

    AST_BUSY_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mem_req |=> $stable(acc_out)); // R12
endmodule

bind mac_tap_engine mac_tap_checker #(.AW(AW), .RW(2*DW)) u_chk (.*);

// File: tb/mac_tap_engine_test.sv
`timescale 1ns/1ps
module mac_tap_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 0, cmd_acc = 0, cmd_shift = 0, flag_clr = 0, ld_ptrs = 0;
    logic [4:0]  shift_amt = '0;
    logic [15:0] ld_base = '0, ld_limit = '0, ld_coef = '0, ld_samp = '0;
    logic        mem_req, mem_ready = 1'b0;
    logic [15:0] mem_addr, mem_rdata = '0;
    logic        busy, done, ovf_pos, ovf_neg;
    logic [31:0] acc_out;
    logic [15:0] coef_ptr, samp_ptr;

    logic [15:0] mem [64];

    logic [31:0] m_acc;
    logic [15:0] m_a, m_k, m_b, m_x;
    logic        m_pos, m_neg;

    int checks = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    mac_tap_engine uut (.*);

    // memory responder with random stalls
    always @(negedge clk) begin
        mem_ready <= ($urandom % 4) != 0;
        mem_rdata <= mem[mem_addr[6:1]];
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog R11: act timeout exp completion");
            finish_run();
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act %h exp %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ring_next(logic [15:0] b, logic [15:0] a, logic [15:0] k);
        logic [15:0] n = b + 16'd2;
        return (n > k) ? a : n;
    endfunction

    function automatic logic [31:0] mul16(logic [15:0] c, logic [15:0] s);
        logic signed [31:0] p = $signed(c) * $signed(s);
        return p;
    endfunction

    task automatic model_tap(bit clr);
        logic [31:0] p, s;
        if (clr) m_acc = '0;
        p = mul16(mem[m_b[6:1]], mem[m_x[6:1]]);
        m_b = ring_next(m_b, m_a, m_k);
        m_x = m_x + 16'd2;
        s = m_acc + p;
        if (!m_acc[31] && !p[31] && s[31] && !m_neg) m_pos = 1'b1;
        if (m_acc[31] && p[31] && !s[31] && !m_pos) m_neg = 1'b1;
        m_acc = s;
    endtask

    task automatic run_tap(bit clr, bit poke);
        model_tap(clr);
        @(negedge clk);
        if (clr) cmd_start = 1; else cmd_acc = 1;
        @(negedge clk);
        cmd_start = 0; cmd_acc = 0;
        chk("R11 busy after accept", {31'd0, busy}, 32'd1);
        if (poke) begin
            cmd_start = 1; cmd_shift = 1; shift_amt = 5'd7;
            @(negedge clk);
            cmd_start = 0; cmd_shift = 0;
        end
        while (!done) @(negedge clk);
        chk(clr ? "R2 acc after start" : "R3 acc after accumulate", acc_out, m_acc);
        chk("R4 coef pointer", {16'd0, coef_ptr}, {16'd0, m_b});
        chk("R5 sample pointer", {16'd0, samp_ptr}, {16'd0, m_x});
        chk("R6 ovf_pos", {31'd0, ovf_pos}, {31'd0, m_pos});
        chk("R7 ovf_neg", {31'd0, ovf_neg}, {31'd0, m_neg});
        if (poke) chk("R12 command while busy ignored", acc_out, m_acc);
    endtask

    task automatic do_shift(logic [4:0] amt);
        @(negedge clk);
        cmd_shift = 1; shift_amt = amt;
        @(negedge clk);
        cmd_shift = 0;
        m_acc = $signed(m_acc) >>> amt;
        chk("R9 arithmetic shift", acc_out, m_acc);
    endtask

    task automatic do_clear();
        @(negedge clk);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        m_pos = 0; m_neg = 0;
        chk("R10 flags cleared", {30'd0, ovf_pos, ovf_neg}, 32'd0);
    endtask

    task automatic do_load(logic [15:0] a, logic [15:0] k, logic [15:0] b, logic [15:0] x);
        @(negedge clk);
        ld_ptrs = 1; ld_base = a; ld_limit = k; ld_coef = b; ld_samp = x;
        @(negedge clk);
        ld_ptrs = 0;
        m_a = a; m_k = k; m_b = b; m_x = x;
        chk("R13 pointer load", {coef_ptr, samp_ptr}, {b, x});
    endtask

    task automatic fill(logic [15:0] coefv, logic [15:0] other);
        for (int i = 0; i < 64; i++) mem[i] = (i >= 8 && i < 16) ? coefv : other;
    endtask

    initial begin
        void'($urandom(32'd4421));
        for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
        m_acc = '0; m_pos = 0; m_neg = 0; m_a = '0; m_k = '0; m_b = '0; m_x = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset acc", acc_out, 32'd0);
        chk("R1 reset status", {27'd0, ovf_pos, ovf_neg, busy, done, mem_req}, 32'd0);
        rst_n = 1;

        // ring wrap: 0x1C -> 0x1E (equal to limit, kept) -> 0x10
        do_load(16'h0010, 16'h001E, 16'h001C, 16'h0040);
        run_tap(1'b1, 1'b0);
        chk("R4 no wrap at limit", {16'd0, coef_ptr}, 32'h001E);
        run_tap(1'b0, 1'b0);
        chk("R4 wrap to base", {16'd0, coef_ptr}, 32'h0010);
        chk("R5 sample pointer linear", {16'd0, samp_ptr}, 32'h0044);

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            int unsigned r = $urandom % 10;
            if (r == 0)      run_tap(1'b1, ($urandom % 4) == 0);
            else if (r < 6)  run_tap(1'b0, ($urandom % 4) == 0);
            else if (r == 6) do_shift(5'($urandom));
            else if (r == 7) begin
                for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
            end else if (r == 8) do_clear();
            else do_load(16'h0010, 16'h0010 + 16'(2 * ($urandom % 8)),
                         16'h0010, 16'h0040);
        end

        // positive overflow with wrap-around
        do_clear();
        do_load(16'h0010, 16'h001E, 16'h0010, 16'h0040);
        fill(16'h8000, 16'h8000);
        run_tap(1'b1, 1'b0);
        run_tap(1'b0, 1'b0);
        chk("R6 wrapped sum", acc_out, 32'h8000_0000);
        chk("R6 pos flag set", {30'd0, ovf_pos, ovf_neg}, 32'd2);

        // negative overflow blocked by positive flag
        fill(16'h7FFF, 16'h8000);
        do_load(16'h0010, 16'h001E, 16'h0010, 16'h0040);
        run_tap(1'b1, 1'b0);
        run_tap(1'b0, 1'b0);
        run_tap(1'b0, 1'b0);
        chk("R8 neg blocked by pos", {30'd0, ovf_pos, ovf_neg}, 32'd2);
        chk("R3 wrapped negative sum", acc_out, 32'h4001_8000);

        do_clear();
        run_tap(1'b1, 1'b0);
        run_tap(1'b0, 1'b0);
        run_tap(1'b0, 1'b0);
        chk("R7 neg flag set", {30'd0, ovf_pos, ovf_neg}, 32'd1);

        fill(16'h8000, 16'h8000);
        do_load(16'h0010, 16'h001E, 16'h0010, 16'h0040);
        run_tap(1'b1, 1'b0);
        run_tap(1'b0, 1'b0);
        chk("R8 pos blocked by neg", {30'd0, ovf_pos, ovf_neg}, 32'd1);

        // shift extremes on a negative value
        do_shift(5'd0);
        chk("R9 shift by 0", acc_out, 32'h8000_0000);
        do_shift(5'd31);
        chk("R9 shift by 31 sign fill", acc_out, 32'hFFFF_FFFF);

        finish_run();
    end
endmodule